// File: doc/BRIEF.md
# Dual Binary/Decimal Address Controller

This block produces the memory address for a sampling recorder. A binary counter supplies the address. A four-digit decimal (BCD) counter steps with it on every count, so the address can be shown in decimal without a conversion stage. Both counters move up or down by one on each step pulse while the recorder runs.

A decimal end-address register is compared with the decimal count digit by digit. The result goes out as a match flag, which the surrounding logic uses to stop an acquisition. While the recorder is stopped, an operator can clear the address or switch a mode flop to edit the end address with the same step pulses.

A scanned four-digit common-cathode seven-segment display shows either the live address or the end address, depending on the mode flop.

Top module: `dual_addr_ctl`

## Requirements
- R1: After reset the address is 0, the end address is 0000, match is 1, the mode is address mode, the direction is up, and digit enable 0 is the one that is active.
- R2: The direction state is set to up when `up_sw` is high and `dn_sw` is low. It is set to down when `dn_sw` is high and `up_sw` is low. When both or neither are high it keeps its value.
- R3: In address mode with `run` high, each clock cycle with `step` high moves the address by one in the current direction. With `step` low, or with `run` low, the address holds.
- R4: Counting up from 4095 gives 0 and the decimal copy reads 0000. Counting down from 0 gives 4095 and the decimal copy reads 4095.
- R5: In address mode the display shows the decimal value of `addr`.
- R6: `zero_btn` high while `run` is low clears the address and its decimal copy on the next edge. While `run` is high it has no effect.
- R7: A rising edge of `final_btn` toggles between address mode and end-address mode, but only while `run` is low. An edge seen while `run` is high is ignored.
- R8: In end-address mode with `run` low, each cycle with `step` high moves the end address by one in decimal in the current direction, wrapping between 9999 and 0000. The address does not change. The display shows the end address.
- R9: `match` is 1 exactly when all four decimal digits of the address equal the four end-address digits.
- R10: The scan advances once every SCAN_DIV clocks through digits 0, 1, 2, 3 and repeats. `dig_en` is one-hot and active high, and bit k enables digit k, where digit 0 is the least significant.
- R11: `seg[6:0]` is {g,f,e,d,c,b,a}, active high, and shows the digit selected by the scan. The patterns are 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F (hex).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | One-cycle step pulse |
| run | input | 1 | 1 = acquisition running, 0 = stopped |
| up_sw | input | 1 | Direction switch, up contact |
| dn_sw | input | 1 | Direction switch, down contact |
| final_btn | input | 1 | Debounced end-address edit button (level) |
| zero_btn | input | 1 | Debounced address clear button (level) |
| addr | output | ADDR_W | Binary memory address |
| match | output | 1 | Decimal address equals end address |
| seg | output | 7 | Segment lines {g..a}, active high |
| dig_en | output | DIGITS | Digit enables, active high |

## Verification
If the decimal copy drifts away from the binary count, the fault is visible in two places. The scanned display stops agreeing with `addr`, and `match` rises at the wrong address, often only after a wrap at 4095 or 0. For that reason both wraps are driven and then read back through the display. A mode flop stuck in the wrong state shows as the display picking the wrong value and as step pulses moving the wrong register, within one step of the stimulus. A stuck or slow scan shows within a few SCAN_DIV periods as a digit that never lights or lights in the wrong order.

// File: rtl/dual_addr_ctl.sv
`timescale 1ns/1ps
module dual_addr_ctl #(
  parameter int ADDR_W   = 12,
  parameter int DIGITS   = 4,
  parameter int SCAN_DIV = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              run,
  input  logic              up_sw,
  input  logic              dn_sw,
  input  logic              final_btn,
  input  logic              zero_btn,
  output logic [ADDR_W-1:0] addr,
  output logic              match,
  output logic [6:0]        seg,
  output logic [DIGITS-1:0] dig_en
);

  localparam int BW     = 4 * DIGITS;
  localparam int SCAN_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam int PRE_W  = $clog2(SCAN_DIV + 1);
  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

  function automatic logic [BW-1:0] to_bcd(input longint unsigned v);
    logic [BW-1:0] r;
    longint unsigned t;
    r = '0;
    t = v;
    for (int i = 0; i < DIGITS; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  localparam logic [BW-1:0] BCD_MAX = to_bcd((longint'(1) << ADDR_W) - 1);

  function automatic logic [BW-1:0] bcd_next(input logic [BW-1:0] v, input logic up);
    logic [BW-1:0] r;
    logic [3:0]    d;
    logic          cy;
    r  = v;
    cy = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      d = r[4*i +: 4];
      if (cy) begin
        if (up) begin
          if (d == 4'd9) d = 4'd0;
          else begin d = d + 4'd1; cy = 1'b0; end
        end else begin
          if (d == 4'd0) d = 4'd9;
          else begin d = d - 4'd1; cy = 1'b0; end
        end
      end
      r[4*i +: 4] = d;
    end
    return r;
  endfunction

  logic [ADDR_W-1:0] addr_q;
  logic [BW-1:0]     bcd_q;
  logic [BW-1:0]     fin_q;
  logic              up_q;
  logic              fmode_q;
  logic              btn_q;
  logic [PRE_W-1:0]  pre_q;
  logic [SCAN_W-1:0] scan_q;

  logic addr_step, fin_step, stopped;
  assign stopped   = ~run;
  assign addr_step = run & step & ~fmode_q;
  assign fin_step  = stopped & step & fmode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q    <= 1'b1;
      fmode_q <= 1'b0;
      btn_q   <= 1'b0;
    end else begin
      btn_q <= final_btn;
      if (up_sw && !dn_sw)      up_q <= 1'b1;
      else if (dn_sw && !up_sw) up_q <= 1'b0;
      if (stopped && final_btn && !btn_q) fmode_q <= ~fmode_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      bcd_q  <= '0;
    end else if (stopped && zero_btn) begin
      addr_q <= '0;
      bcd_q  <= '0;
    end else if (addr_step) begin
      if (up_q) begin
        addr_q <= addr_q + 1'b1;
        bcd_q  <= (addr_q == ADDR_MAX) ? '0 : bcd_next(bcd_q, 1'b1);
      end else begin
        addr_q <= addr_q - 1'b1;
        bcd_q  <= (addr_q == '0) ? BCD_MAX : bcd_next(bcd_q, 1'b0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        fin_q <= '0;
    else if (fin_step) fin_q <= bcd_next(fin_q, up_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      scan_q <= '0;
    end else if (pre_q == PRE_W'(SCAN_DIV - 1)) begin
      pre_q  <= '0;
      scan_q <= (scan_q == SCAN_W'(DIGITS - 1)) ? '0 : scan_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  logic [BW-1:0] shown;
  logic [3:0]    cur_dig;
  assign shown   = fmode_q ? fin_q : bcd_q;
  assign cur_dig = shown[4*int'(scan_q) +: 4];

  always_comb begin
    case (cur_dig)
      4'd0: seg = 7'h3F;
      4'd1: seg = 7'h06;
      4'd2: seg = 7'h5B;
      4'd3: seg = 7'h4F;
      4'd4: seg = 7'h66;
      4'd5: seg = 7'h6D;
      4'd6: seg = 7'h7D;
      4'd7: seg = 7'h07;
      4'd8: seg = 7'h7F;
      4'd9: seg = 7'h6F;
      default: seg = 7'h00;
    endcase
  end

  assign dig_en = DIGITS'(1) << scan_q;
  assign addr   = addr_q;
  assign match  = (bcd_q == fin_q);

endmodule

// File: rtl/dual_addr_ctl_chk.sv
`timescale 1ns/1ps
module dual_addr_ctl_chk #(
  parameter int ADDR_W = 12,
  parameter int DIGITS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step,
  input logic              run,
  input logic              zero_btn,
  input logic [ADDR_W-1:0] addr,
  input logic [DIGITS-1:0] dig_en,
  input logic              up_q,
  input logic              fmode_q,
  input logic [4*DIGITS-1:0] fin_q
);

  // R3
  hold_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !(zero_btn && !run)) |=> $stable(addr));

  // R3
  hold_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !zero_btn) |=> $stable(addr));

  // R4
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && !fmode_q && up_q && addr == '1) |=> addr == '0);

  // R4
  dn_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && !fmode_q && !up_q && addr == '0) |=> addr == '1);

  // R6
  zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && zero_btn) |=> addr == '0);

  // R7
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(fmode_q));

  // R8
  fin_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run || !fmode_q) |=> $stable(fin_q));

  // R10
  digit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dig_en) == 1);

endmodule

bind dual_addr_ctl dual_addr_ctl_chk #(.ADDR_W(ADDR_W), .DIGITS(DIGITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .step(step), .run(run), .zero_btn(zero_btn),
  .addr(addr), .dig_en(dig_en), .up_q(up_q), .fmode_q(fmode_q), .fin_q(fin_q)
);

// File: tb/dual_addr_ctl_tb_top.sv
`timescale 1ns/1ps
module dual_addr_ctl_tb_top;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0, run = 1'b0, up_sw = 1'b0, dn_sw = 1'b0;
  logic final_btn = 1'b0, zero_btn = 1'b0;
  logic [11:0] addr;
  logic        match;
  logic [6:0]  seg;
  logic [3:0]  dig_en;

  int vectors = 0;
  int miscomp = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_addr_ctl #(.ADDR_W(12), .DIGITS(4), .SCAN_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .step(step), .run(run), .up_sw(up_sw),
    .dn_sw(dn_sw), .final_btn(final_btn), .zero_btn(zero_btn),
    .addr(addr), .match(match), .seg(seg), .dig_en(dig_en));

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscomp++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int seg2dig(input logic [6:0] s);
    case (s)
      7'h3F: return 0; 7'h06: return 1; 7'h5B: return 2; 7'h4F: return 3;
      7'h66: return 4; 7'h6D: return 5; 7'h7D: return 6; 7'h07: return 7;
      7'h7F: return 8; 7'h6F: return 9;
      default: return 15;
    endcase
  endfunction

  task automatic read_disp(output int val);
    int mul;
    val = 0;
    mul = 1;
    for (int k = 0; k < 4; k++) begin
      int n;
      n = 0;
      while (dig_en != 4'(1 << k) && n < 64) begin
        @(negedge clk);
        n++;
      end
      val += seg2dig(seg) * mul;
      mul *= 10;
    end
  endtask

  task automatic step_n(input int n);
    step = 1'b1;
    repeat (n) @(negedge clk);
    step = 1'b0;
  endtask

  task automatic press_final();
    final_btn = 1'b1; @(negedge clk);
    final_btn = 1'b0; @(negedge clk);
  endtask

  task automatic set_dir(input logic u, input logic d);
    up_sw = u; dn_sw = d; @(negedge clk);
    up_sw = 1'b0; dn_sw = 1'b0;
  endtask

  task automatic t_reset();
    int v;
    check("R1 addr", addr, 0);
    check("R1 match", match, 1);
    check("R1 dig_en", dig_en, 1);
    read_disp(v);
    check("R1 display", v, 0);
  endtask

  task automatic t_count();
    int v;
    run = 1'b1;
    step_n(7);
    check("R3 count up", addr, 7);
    read_disp(v);
    check("R5 display addr", v, 7);
    repeat (3) @(negedge clk);
    check("R3 hold no step", addr, 7);
    run = 1'b0;
    step_n(3);
    check("R3 hold stopped", addr, 7);
  endtask

  task automatic t_dir();
    run = 1'b1;
    set_dir(1'b0, 1'b1);
    step_n(2);
    check("R2 down", addr, 5);
    set_dir(1'b1, 1'b1);
    step_n(1);
    check("R2 both holds", addr, 4);
    set_dir(1'b1, 1'b0);
    step_n(1);
    check("R2 up", addr, 5);
  endtask

  task automatic t_zero();
    run = 1'b1;
    zero_btn = 1'b1; @(negedge clk); zero_btn = 1'b0; @(negedge clk);
    check("R6 ignored in run", addr, 5);
    run = 1'b0;
    zero_btn = 1'b1; @(negedge clk); zero_btn = 1'b0;
    check("R6 clear", addr, 0);
  endtask

  task automatic t_wrap();
    int v;
    run = 1'b1;
    step_n(4095);
    check("R4 top", addr, 4095);
    read_disp(v);
    check("R5 display 4095", v, 4095);
    step_n(1);
    check("R4 up wrap", addr, 0);
    read_disp(v);
    check("R4 bcd up wrap", v, 0);
    set_dir(1'b0, 1'b1);
    step_n(1);
    check("R4 down wrap", addr, 4095);
    read_disp(v);
    check("R4 bcd down wrap", v, 4095);
    set_dir(1'b1, 1'b0);
    run = 1'b0;
    zero_btn = 1'b1; @(negedge clk); zero_btn = 1'b0;
  endtask

  task automatic t_final();
    int v;
    run = 1'b0;
    press_final();
    read_disp(v);
    check("R7 final shown", v, 0);
    step_n(5);
    read_disp(v);
    check("R8 edit up", v, 5);
    check("R8 addr kept", addr, 0);
    check("R9 no match", match, 0);
    set_dir(1'b0, 1'b1);
    step_n(6);
    read_disp(v);
    check("R8 wrap 9999", v, 9999);
    set_dir(1'b1, 1'b0);
    step_n(6);
    read_disp(v);
    check("R8 wrap up", v, 5);
    run = 1'b1;
    press_final();
    read_disp(v);
    check("R7 toggle ignored in run", v, 5);
    run = 1'b0;
    press_final();
    read_disp(v);
    check("R7 back to addr", v, 0);
  endtask

  task automatic t_match();
    run = 1'b1;
    step_n(5);
    check("R9 match", match, 1);
    step_n(1);
    check("R9 mismatch", match, 0);
    run = 1'b0;
    step_n(2);
    check("R8 addr mode stop step", addr, 6);
  endtask

  task automatic t_scan();
    int n;
    n = 0;
    while (dig_en != 4'b0001 && n < 64) begin @(negedge clk); n++; end
    while (dig_en == 4'b0001 && n < 64) begin @(negedge clk); n++; end
    n = 0;
    while (dig_en == 4'b0010 && n < 64) begin @(negedge clk); n++; end
    check("R10 dwell", n, DIV);
    check("R10 order", dig_en, 4'b0100);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R10 onehot", $countones(dig_en), 1);
    end
    check("R11 seg digit valid", seg2dig(seg) < 10, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_dir();
    t_zero();
    t_wrap();
    t_final();
    t_match();
    t_scan();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++;
      miscomp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end
endmodule